// File: doc/BRIEF.md
# Strided DMA Address Generator

This block produces, beat by beat, the two addresses one DMA channel needs. One is the address in the tightly coupled memory (the internal side). The other is the address in the external memory. Software gives it a start address for each side, a last internal address, a transaction size code and a byte stride, then issues a start pulse.

The internal address always moves by the transaction size. The external address moves by the stride instead. A zero stride keeps the external address fixed, which suits a FIFO or another volatile location. Before a transfer begins, every parameter is checked for alignment. A misaligned parameter raises a bad-parameter flag, and the transfer does not start.

The data mover consumes beats through a single beat-accept input. Addresses advance only when that input is high. A stop pulse ends the transfer early. When it does, the block hands back the addresses of the next beat not yet taken, so that a later start resumes at that point. The direction and target-memory selections are captured at start and carried alongside the addresses.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `busy`, `done`, `bad_param` and `resume_vld` are 0, and `int_addr` and `ext_addr` are 0.
- R2: The size code maps as 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes and 11 = 8 bytes. The internal address steps by that byte count on each accepted beat, whatever the stride.
- R3: The external address steps by the 12-bit unsigned stride on each accepted beat. A stride of 0 keeps it constant for the whole transfer.
- R4: A start with a stride that is not a multiple of the transaction size sets `bad_param` and leaves `busy` at 0.
- R5: A start sets `bad_param` and leaves `busy` at 0 in any of these cases: the internal start, the external start or the internal end address is not aligned to the transaction size, or the internal end address is below the internal start address.
- R6: One cycle after an accepted start, `busy` is 1, `int_addr` and `ext_addr` show the start addresses, and `done` and `bad_param` are 0.
- R7: While `busy` is 1 and `beat_accept` is 0, both addresses hold their values.
- R8: The cycle after the beat whose internal address equals the end address is accepted, `busy` is 0 and `done` is 1.
- R9: A stop while busy drops `busy` one cycle later. If that last beat was not the final one, the stop also pulses `resume_vld` for one cycle. `resume_int_addr` and `resume_ext_addr` then hold the addresses of the next beat not yet accepted, counting a beat accepted in the stop cycle.
- R10: The size, stride, end address, direction (`xfer_dir`: 0 = external to internal, 1 = internal to external) and target (`xfer_itcm`: 0 = data memory, 1 = instruction memory) are captured at start. Changes to these inputs during a transfer have no effect.
- R11: A start pulse while `busy` is 1 is ignored, and the addresses continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_size | input | 2 | Transaction size code |
| cfg_stride | input | 12 | External address step in bytes |
| cfg_dir | input | 1 | Direction selection |
| cfg_itcm | input | 1 | Target memory selection |
| int_start | input | 32 | Internal start address |
| int_end | input | 32 | Internal address of the last beat |
| ext_start | input | 32 | External start address |
| cmd_start | input | 1 | Start pulse |
| cmd_stop | input | 1 | Stop pulse |
| beat_accept | input | 1 | Current beat taken by the data mover |
| busy | output | 1 | Transfer in progress, addresses valid |
| int_addr | output | 32 | Current internal address |
| ext_addr | output | 32 | Current external address |
| xfer_dir | output | 1 | Captured direction |
| xfer_itcm | output | 1 | Captured target |
| done | output | 1 | Last beat taken (held until the next start) |
| bad_param | output | 1 | Last start rejected (held until the next start) |
| resume_vld | output | 1 | One-cycle pulse: resume addresses updated |
| resume_int_addr | output | 32 | Internal address to restart from |
| resume_ext_addr | output | 32 | External address to restart from |

## Verification
The main sweep covers every size code, each combined with a zero stride, a stride equal to the size, a multiple of the size, and the largest aligned stride. Transfer lengths run from one to three beats. This separates the internal step from the external step, and shows that a zero stride holds the external address. A one-beat transfer checks the end comparison against the first beat. Idle cycles are inserted between beats, so advancing without an accept would be caught.

Rejected starts use a stride that is odd in the low bits, misaligned start and end addresses, and an end address below the start. Each of these has to leave the channel idle. A stop issued together with an accepted beat, followed by a restart from the returned addresses, shows that no beat is lost or repeated. Changing the configuration mid-run, and pulsing start during a run, must leave the addresses on their original course.

// File: rtl/dma_ag_pkg.sv
// Package: types and helpers shared by the address generator.
// Assumes the size code is two bits with a power-of-two byte count.
package dma_ag_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } xfer_size_e;

    // Byte count of one transaction for a size code.
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // Low-bit mask that must be zero for alignment to a size code.
    function automatic logic [2:0] size_mask(input logic [1:0] code);
        logic [3:0] b;
        b = size_bytes(code) - 4'd1;
        return b[2:0];
    endfunction

endpackage

// File: rtl/dma_ag_param_check.sv
// Module: combinational validity check of transfer parameters.
// Flags a misaligned stride, misaligned addresses, or an end below the start.
// Assumes ADDR_W and STRIDE_W are at least 3.
module dma_ag_param_check
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 12
) (
    input  logic [1:0]          size_code,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [ADDR_W-1:0]   int_start,
    input  logic [ADDR_W-1:0]   int_end,
    input  logic [ADDR_W-1:0]   ext_start,
    output logic                stride_ok,
    output logic                addr_ok,
    output logic                params_ok
);

    logic [2:0] mask;

    // Compare each low-bit field with the size mask and the range order.
    always_comb begin
        mask      = size_mask(size_code);
        stride_ok = (stride[2:0] & mask) == 3'd0;
        addr_ok   = ((int_start[2:0] & mask) == 3'd0) &&
                    ((int_end[2:0]   & mask) == 3'd0) &&
                    ((ext_start[2:0] & mask) == 3'd0) &&
                    (int_end >= int_start);
        params_ok = stride_ok && addr_ok;
    end

endmodule

// File: rtl/dma_ag_addr_lane.sv
// Module: one address register with load and step.
// Load wins over advance; the next-state value is exported for snapshots.
module dma_ag_addr_lane #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  logic [ADDR_W-1:0] step,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] addr_d
);

    // Select the next address: load, step, or hold.
    always_comb begin
        if (load)     addr_d = load_val;
        else if (adv) addr_d = addr_q + step;
        else          addr_d = addr_q;
    end

    // Register the address.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

endmodule

// File: rtl/dma_ag_ctrl.sv
// Module: run/idle control of the address generator.
// Accepts a start only while idle, ends on the final beat or on a stop, and
// keeps the done and bad-parameter flags until the next accepted start pulse.
module dma_ag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic beat_accept,
    input  logic params_ok,
    input  logic at_end,
    output logic load,
    output logic adv,
    output logic stop_take,
    output logic busy,
    output logic done,
    output logic bad_param,
    output logic resume_vld
);

    logic start_take;
    logic finish;

    // Decode this cycle's events from the current state.
    always_comb begin
        start_take = cmd_start && !busy;
        load       = start_take && params_ok;
        finish     = busy && beat_accept && at_end;
        adv        = busy && beat_accept && !at_end;
        stop_take  = busy && cmd_stop && !finish;
    end

    // Update the run state and the status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            bad_param  <= 1'b0;
            resume_vld <= 1'b0;
        end else begin
            resume_vld <= stop_take;
            if (start_take) begin
                busy      <= params_ok;
                done      <= 1'b0;
                bad_param <= !params_ok;
            end else if (finish) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (stop_take) begin
                busy <= 1'b0;
            end
        end
    end

    // R4/R5: a rejected start never begins a run.
    p_reject_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy && !params_ok) |=> (!busy && bad_param));

    // R8: the final beat ends the run with done set.
    p_finish_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat_accept && at_end) |=> (!busy && done));

    // R9: a resume pulse lasts one cycle and only while idle.
    p_resume_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vld |-> (!busy && !$past(resume_vld)));

    // R11: a start during a run leaves it running.
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start && !cmd_stop && !beat_accept) |=> busy);

endmodule

// File: rtl/dma_addr_gen.sv
// Module: strided DMA address generator, top level.
// Internal address steps by the transaction size; external address steps by
// the captured stride. Configuration is captured on an accepted start.
// Assumes ADDR_W > STRIDE_W.
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_size,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic                cfg_dir,
    input  logic                cfg_itcm,
    input  logic [ADDR_W-1:0]   int_start,
    input  logic [ADDR_W-1:0]   int_end,
    input  logic [ADDR_W-1:0]   ext_start,
    input  logic                cmd_start,
    input  logic                cmd_stop,
    input  logic                beat_accept,
    output logic                busy,
    output logic [ADDR_W-1:0]   int_addr,
    output logic [ADDR_W-1:0]   ext_addr,
    output logic                xfer_dir,
    output logic                xfer_itcm,
    output logic                done,
    output logic                bad_param,
    output logic                resume_vld,
    output logic [ADDR_W-1:0]   resume_int_addr,
    output logic [ADDR_W-1:0]   resume_ext_addr
);

    localparam int NLANE  = 2;
    localparam int L_INT  = 0;
    localparam int L_EXT  = 1;
    localparam int PAD_SZ = ADDR_W - 4;
    localparam int PAD_ST = ADDR_W - STRIDE_W;

    logic                stride_ok, addr_ok, params_ok;
    logic                load, adv, stop_take, at_end;
    logic [1:0]          size_q;
    logic [STRIDE_W-1:0] stride_q;
    logic [ADDR_W-1:0]   end_q;
    logic [ADDR_W-1:0]   lane_start [NLANE];
    logic [ADDR_W-1:0]   lane_step  [NLANE];
    logic [ADDR_W-1:0]   lane_q     [NLANE];
    logic [ADDR_W-1:0]   lane_d     [NLANE];

    dma_ag_param_check #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_check (
        .size_code (cfg_size),
        .stride    (cfg_stride),
        .int_start (int_start),
        .int_end   (int_end),
        .ext_start (ext_start),
        .stride_ok (stride_ok),
        .addr_ok   (addr_ok),
        .params_ok (params_ok)
    );

    dma_ag_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .beat_accept (beat_accept),
        .params_ok   (params_ok),
        .at_end      (at_end),
        .load        (load),
        .adv         (adv),
        .stop_take   (stop_take),
        .busy        (busy),
        .done        (done),
        .bad_param   (bad_param),
        .resume_vld  (resume_vld)
    );

    // Capture the transfer configuration on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q    <= SZ_BYTE;
            stride_q  <= '0;
            end_q     <= '0;
            xfer_dir  <= 1'b0;
            xfer_itcm <= 1'b0;
        end else if (load) begin
            size_q    <= cfg_size;
            stride_q  <= cfg_stride;
            end_q     <= int_end;
            xfer_dir  <= cfg_dir;
            xfer_itcm <= cfg_itcm;
        end
    end

    // Per-lane start value and step size.
    always_comb begin
        lane_start[L_INT] = int_start;
        lane_start[L_EXT] = ext_start;
        lane_step[L_INT]  = {{PAD_SZ{1'b0}}, size_bytes(size_q)};
        lane_step[L_EXT]  = {{PAD_ST{1'b0}}, stride_q};
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        dma_ag_addr_lane #(.ADDR_W(ADDR_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .load_val (lane_start[g]),
            .adv      (adv),
            .step     (lane_step[g]),
            .addr_q   (lane_q[g]),
            .addr_d   (lane_d[g])
        );
    end

    assign int_addr = lane_q[L_INT];
    assign ext_addr = lane_q[L_EXT];
    assign at_end   = (lane_q[L_INT] == end_q);

    // Snapshot the next untaken beat's addresses on a stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_int_addr <= '0;
            resume_ext_addr <= '0;
        end else if (stop_take) begin
            resume_int_addr <= lane_d[L_INT];
            resume_ext_addr <= lane_d[L_EXT];
        end
    end

    // R2: internal address moves by the captured size on a non-final beat.
    p_int_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat_accept && !at_end && !cmd_start) |=>
        (int_addr == $past(int_addr) + {{PAD_SZ{1'b0}}, size_bytes($past(size_q))}));

    // R3: a zero stride keeps the external address fixed.
    p_ext_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat_accept && stride_q == '0) |=> $stable(ext_addr));

    // R7: no accept, no movement.
    p_hold_no_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_accept) |=> ($stable(int_addr) && $stable(ext_addr)));

    // R10: captured direction and target stay fixed during a run.
    p_cfg_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(xfer_dir) && $stable(xfer_itcm)));

endmodule

// File: tb/dma_addr_gen_bench.sv
module dma_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_size = '0;
    logic [11:0] cfg_stride = '0;
    logic        cfg_dir = 1'b0, cfg_itcm = 1'b0;
    logic [31:0] int_start = '0, int_end = '0, ext_start = '0;
    logic        cmd_start = 1'b0, cmd_stop = 1'b0, beat_accept = 1'b0;
    logic        busy, xfer_dir, xfer_itcm, done, bad_param, resume_vld;
    logic [31:0] int_addr, ext_addr, resume_int_addr, resume_ext_addr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dma_addr_gen u_dma_addr_gen (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_stride(cfg_stride),
        .cfg_dir(cfg_dir), .cfg_itcm(cfg_itcm), .int_start(int_start),
        .int_end(int_end), .ext_start(ext_start), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .beat_accept(beat_accept), .busy(busy),
        .int_addr(int_addr), .ext_addr(ext_addr), .xfer_dir(xfer_dir),
        .xfer_itcm(xfer_itcm), .done(done), .bad_param(bad_param),
        .resume_vld(resume_vld), .resume_int_addr(resume_int_addr),
        .resume_ext_addr(resume_ext_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    // Pulse start for one cycle; outputs then reflect the result.
    task automatic do_start(input logic [1:0] sz, input logic [11:0] st,
                            input logic [31:0] is, input logic [31:0] ie,
                            input logic [31:0] es);
        cfg_size = sz; cfg_stride = st; int_start = is; int_end = ie; ext_start = es;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic accept_beat();
        beat_accept = 1'b1;
        @(negedge clk);
        beat_accept = 1'b0;
    endtask

    function automatic logic [31:0] nbytes(input logic [1:0] sz);
        return 32'd1 << sz;
    endfunction

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] i0, e0, b;
        logic [11:0] strides [4];
        repeat (3) @(negedge clk);
        // R1: reset state
        eq("R1", "busy", {31'd0, busy}, 0);
        eq("R1", "done", {31'd0, done}, 0);
        eq("R1", "bad_param", {31'd0, bad_param}, 0);
        eq("R1", "resume_vld", {31'd0, resume_vld}, 0);
        eq("R1", "int_addr", int_addr, 0);
        eq("R1", "ext_addr", ext_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R6 R7 R8 R10: sweep sizes, strides, lengths
        for (int sz = 0; sz < 4; sz++) begin
            b = nbytes(sz[1:0]);
            strides[0] = 12'd0;
            strides[1] = b[11:0];
            strides[2] = 12'(3 * b);
            strides[3] = 12'hFFF & ~12'(b - 1);
            for (int si = 0; si < 4; si++) begin
                for (int n = 1; n <= 3; n++) begin
                    i0 = 32'h0000_0100 + 32'(sz * 64);
                    e0 = 32'h8000_0040;
                    cfg_dir = sz[0]; cfg_itcm = sz[1];
                    do_start(sz[1:0], strides[si], i0, i0 + 32'(n - 1) * b, e0);
                    eq("R6", "busy after start", {31'd0, busy}, 1);
                    eq("R6", "done cleared", {31'd0, done}, 0);
                    eq("R10", "xfer_dir", {31'd0, xfer_dir}, {31'd0, sz[0]});
                    eq("R10", "xfer_itcm", {31'd0, xfer_itcm}, {31'd0, sz[1]});
                    // R10: change inputs mid-run
                    cfg_stride = 12'h004; cfg_dir = ~cfg_dir; int_end = 32'h0;
                    for (int k = 0; k < n; k++) begin
                        eq("R2", "int_addr", int_addr, i0 + 32'(k) * b);
                        eq("R3", "ext_addr", ext_addr, e0 + 32'(k) * {20'd0, strides[si]});
                        @(negedge clk);
                        eq("R7", "int hold", int_addr, i0 + 32'(k) * b);
                        eq("R7", "ext hold", ext_addr, e0 + 32'(k) * {20'd0, strides[si]});
                        accept_beat();
                    end
                    eq("R8", "busy after last", {31'd0, busy}, 0);
                    eq("R8", "done after last", {31'd0, done}, 1);
                    eq("R10", "dir held", {31'd0, xfer_dir}, {31'd0, sz[0]});
                end
            end
        end

        // R4: misaligned stride
        for (int sz = 1; sz < 4; sz++) begin
            do_start(sz[1:0], 12'd1 << (sz - 1), 32'h200, 32'h240, 32'h400);
            eq("R4", "bad_param", {31'd0, bad_param}, 1);
            eq("R4", "busy", {31'd0, busy}, 0);
        end
        // R5: misaligned internal start, external start, end; end below start
        do_start(2'd2, 12'd4, 32'h202, 32'h240, 32'h400);
        eq("R5", "int start misaligned", {31'd0, busy, bad_param}, 32'd1);
        do_start(2'd3, 12'd8, 32'h200, 32'h240, 32'h404);
        eq("R5", "ext start misaligned", {31'd0, busy, bad_param}, 32'd1);
        do_start(2'd1, 12'd2, 32'h200, 32'h241, 32'h400);
        eq("R5", "end misaligned", {31'd0, busy, bad_param}, 32'd1);
        do_start(2'd0, 12'd1, 32'h200, 32'h1FF, 32'h400);
        eq("R5", "end below start", {31'd0, busy, bad_param}, 32'd1);
        // byte size accepts odd values
        do_start(2'd0, 12'd3, 32'h201, 32'h201, 32'h403);
        eq("R5", "byte odd ok", {31'd0, busy, bad_param}, 32'd2);
        accept_beat();

        // R9: stop with a simultaneous accepted beat, then resume
        do_start(2'd2, 12'd8, 32'h1000, 32'h1010, 32'h2000);
        accept_beat();
        accept_beat();
        // R11: start during run ignored
        do_start(2'd0, 12'd1, 32'h3001, 32'h3001, 32'h5001);
        eq("R11", "int after ignored start", int_addr, 32'h1008);
        eq("R11", "ext after ignored start", ext_addr, 32'h2010);
        eq("R11", "busy", {31'd0, busy}, 1);
        beat_accept = 1'b1; cmd_stop = 1'b1;
        @(negedge clk);
        beat_accept = 1'b0; cmd_stop = 1'b0;
        eq("R9", "busy after stop", {31'd0, busy}, 0);
        eq("R9", "resume_vld", {31'd0, resume_vld}, 1);
        eq("R9", "done not set", {31'd0, done}, 0);
        eq("R9", "resume_int", resume_int_addr, 32'h100C);
        eq("R9", "resume_ext", resume_ext_addr, 32'h2018);
        @(negedge clk);
        eq("R9", "resume pulse ends", {31'd0, resume_vld}, 0);
        do_start(2'd2, 12'd8, resume_int_addr, 32'h1010, resume_ext_addr);
        eq("R9", "resumed int", int_addr, 32'h100C);
        eq("R9", "resumed ext", ext_addr, 32'h2018);
        accept_beat();
        eq("R9", "resumed final int", int_addr, 32'h1010);
        eq("R9", "resumed final ext", ext_addr, 32'h2020);
        accept_beat();
        eq("R8", "done after resume", {31'd0, done, busy}, 32'd2);
        // R9: stop on final beat gives done, no resume
        do_start(2'd0, 12'd0, 32'h10, 32'h10, 32'h20);
        beat_accept = 1'b1; cmd_stop = 1'b1;
        @(negedge clk);
        beat_accept = 1'b0; cmd_stop = 1'b0;
        eq("R9", "final-beat stop", {30'd0, done, resume_vld}, 32'd2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule